// File: doc/BRIEF.md
# Two-Phase Link Lock Trainer

This controller brings up a serial display link in two phases. On a start request it unmasks the bit-lock and symbol-lock status flags. It clears any stale flags and waits a fixed unmask interval. It then programs the receiver's miscellaneous configuration codes, enables the receiver and selects training pattern 1. It steps the transmitter drive setting through four levels. After each new level it waits a settle interval and then polls the sticky bit-lock flag a bounded number of times, with a fixed gap between polls.

Once bit lock is seen, the controller clears that flag and switches to training pattern 2. It returns the drive setting to the lowest level, waits a short interval and repeats the same sweep while polling for symbol lock. If the four levels of a phase run out with no lock, the controller reports which phase failed. It also turns the pattern off and disables the receiver. The lock inputs come from the link receiver as single-cycle pulses. Each pulse sets a sticky flag, which software can clear by writing one. All intervals are given in microseconds and scaled by a cycles-per-microsecond parameter.

Top module: `link_lock_trainer`

## Requirements
- R1: After reset, result is 0 (idle), pattern_sel is 0 (off), lock_mask is 2'b11, rx_enable is 0, lock_sts is 2'b00, and both misc codes are 0.
- R2: A start pulse while not busy clears lock_mask to 2'b00 and clears both lock_sts flags, and sets result to 1 (busy). pattern_sel becomes 1 exactly UNMASK_US*CYC_PER_US cycles after the start edge.
- R3: misc_tp_code holds 48 and misc_delay_code holds 90 before rx_enable rises. rx_enable rises in the same cycle that pattern_sel becomes 1.
- R4: In each phase, drive_code starts at 0 and rises by one per step (0=400 mV/0 dB, 1=400 mV/6 dB, 2=600 mV/3.5 dB, 3=800 mV/0 dB). Each step is a SETTLE_US wait followed by up to POLLS polls spaced GAP_US apart.
- R5: Phase 1 polls lock_sts bit 0 (bit lock). On a hit it clears that bit, sets pattern_sel to 2, returns drive_code to 0 and waits PH2_US before sweeping again. Phase 2 polls lock_sts bit 1 (symbol lock).
- R6: A symbol-lock hit in phase 2 sets result to 2 (pass) and pattern_sel to 0, and clears lock_sts bit 1. rx_enable stays 1.
- R7: If a phase ends its last poll at drive 3 with no lock, result becomes 3 (phase 1 fail) or 4 (phase 2 fail), with pattern_sel 0 and rx_enable 0. A run with no lock at all ends exactly UNMASK + 4*(SETTLE + POLLS + (POLLS-1)*GAP) cycles after the start edge, with intervals counted in cycles.
- R8: A pulse on bit_lock_in (bit 0) or sym_lock_in (bit 1) sets its lock_sts flag only while its lock_mask bit is 0. The flag then stays set.
- R9: Writing one to a sts_clr bit clears that flag on the next edge. If a set pulse and a clear arrive in the same cycle, the set wins.
- R10: A start pulse while result is 1 (busy) has no effect on the sequence or its timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a training run (one-cycle pulse) |
| bit_lock_in | input | 1 | Bit-lock event pulse from receiver |
| sym_lock_in | input | 1 | Symbol-lock event pulse from receiver |
| sts_clr | input | 2 | Write-one-to-clear for lock_sts |
| lock_sts | output | 2 | Sticky flags: bit 0 bit lock, bit 1 symbol lock |
| lock_mask | output | 2 | Mask bits for the two flags (1 = masked) |
| pattern_sel | output | 2 | Training pattern: 0 off, 1 pattern 1, 2 pattern 2 |
| drive_code | output | DRV_W | Drive level index 0..DRIVES-1 |
| rx_enable | output | 1 | Receiver enable |
| misc_tp_code | output | 8 | Receiver pattern-1-to-2 code |
| misc_delay_code | output | 8 | Receiver delay code |
| result | output | 3 | 0 idle, 1 busy, 2 pass, 3 phase 1 fail, 4 phase 2 fail |

## Verification
The bench sets CYC_PER_US to 2 and keeps the microsecond counts, poll count and drive count at their defaults. A complete failed sweep of one phase then takes a few thousand cycles. This brings every drive level, the last poll of a level and the exact end-of-run cycle count within reach of short runs. The table rows place lock events at early and late offsets within chosen drive levels, and include runs that exhaust each phase.

// File: rtl/lt_pkg.sv
package lt_pkg;
  typedef enum logic [2:0] {
    RES_IDLE  = 3'd0,
    RES_BUSY  = 3'd1,
    RES_PASS  = 3'd2,
    RES_FAIL1 = 3'd3,
    RES_FAIL2 = 3'd4
  } res_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNMASK,
    ST_SETTLE,
    ST_POLL,
    ST_GAP,
    ST_PH2
  } st_e;

  localparam logic [1:0] PAT_OFF = 2'd0;
  localparam logic [1:0] PAT_ONE = 2'd1;
  localparam logic [1:0] PAT_TWO = 2'd2;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/lt_timer.sv
module lt_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && !load) |=> (cnt == '0));
endmodule

// File: rtl/lt_lock_status.sv
module lt_lock_status #(
  parameter int NFLAG = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] mask,
  input  logic [NFLAG-1:0] set_in,
  input  logic [NFLAG-1:0] host_clr,
  input  logic [NFLAG-1:0] int_clr,
  output logic [NFLAG-1:0] flags
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                          flags[i] <= 1'b0;
      else if (set_in[i] && !mask[i])   flags[i] <= 1'b1;
      else if (host_clr[i] || int_clr[i]) flags[i] <= 1'b0;
    end

    // R8
    masked_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!flags[i] && mask[i] && !rst) |=> !flags[i]);
    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (flags[i] && !host_clr[i] && !int_clr[i]) |=> flags[i]);
    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (set_in[i] && !mask[i]) |=> flags[i]);
  end
endmodule

// File: rtl/lt_train_fsm.sv
module lt_train_fsm
  import lt_pkg::*;
#(
  parameter int CYC_PER_US = 100,
  parameter int UNMASK_US  = 150,
  parameter int SETTLE_US  = 500,
  parameter int GAP_US     = 50,
  parameter int PH2_US     = 150,
  parameter int POLLS      = 5,
  parameter int DRIVES     = 4,
  parameter int TP_CODE    = 48,
  parameter int DLY_CODE   = 90,
  parameter int TW         = 16,
  localparam int DRV_W     = (DRIVES > 1) ? $clog2(DRIVES) : 1,
  localparam int PW        = (POLLS > 1) ? $clog2(POLLS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       flags,
  input  logic             expired,
  output logic             load,
  output logic [TW-1:0]    load_val,
  output logic [1:0]       mask,
  output logic [1:0]       int_clr,
  output logic [1:0]       pattern,
  output logic [DRV_W-1:0] drive,
  output logic             rx_en,
  output logic [7:0]       misc_tp,
  output logic [7:0]       misc_dly,
  output logic [2:0]       result_o
);
  localparam logic [TW-1:0] T_UNMASK = TW'(UNMASK_US * CYC_PER_US - 1);
  localparam logic [TW-1:0] T_SETTLE = TW'(SETTLE_US * CYC_PER_US - 1);
  localparam logic [TW-1:0] T_GAP    = TW'(GAP_US * CYC_PER_US - 1);
  localparam logic [TW-1:0] T_PH2    = TW'(PH2_US * CYC_PER_US - 1);
  localparam logic [PW-1:0] LAST_POLL  = PW'(POLLS - 1);
  localparam logic [DRV_W-1:0] LAST_DRV = DRV_W'(DRIVES - 1);

  st_e             state, state_n;
  res_e            result;
  logic            phase;
  logic [PW-1:0]   poll_cnt;
  logic            hit;

  assign hit      = phase ? flags[1] : flags[0];
  assign result_o = result;

  always_comb begin
    state_n = state;
    case (state)
      ST_IDLE:   if (start) state_n = ST_UNMASK;
      ST_UNMASK: if (expired) state_n = ST_SETTLE;
      ST_SETTLE: if (expired) state_n = ST_POLL;
      ST_GAP:    if (expired) state_n = ST_POLL;
      ST_PH2:    if (expired) state_n = ST_SETTLE;
      ST_POLL: begin
        if (hit)                        state_n = phase ? ST_IDLE : ST_PH2;
        else if (poll_cnt != LAST_POLL) state_n = ST_GAP;
        else if (drive != LAST_DRV)     state_n = ST_SETTLE;
        else                            state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_comb begin
    load     = (state_n != state) &&
               (state_n == ST_UNMASK || state_n == ST_SETTLE ||
                state_n == ST_GAP || state_n == ST_PH2);
    case (state_n)
      ST_UNMASK: load_val = T_UNMASK;
      ST_SETTLE: load_val = T_SETTLE;
      ST_GAP:    load_val = T_GAP;
      ST_PH2:    load_val = T_PH2;
      default:   load_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      result   <= RES_IDLE;
      phase    <= 1'b0;
      poll_cnt <= '0;
      drive    <= '0;
      pattern  <= PAT_OFF;
      mask     <= 2'b11;
      int_clr  <= 2'b00;
      rx_en    <= 1'b0;
      misc_tp  <= 8'd0;
      misc_dly <= 8'd0;
    end else begin
      state   <= state_n;
      int_clr <= 2'b00;
      case (state)
        ST_IDLE: if (start) begin
          mask     <= 2'b00;
          int_clr  <= 2'b11;
          result   <= RES_BUSY;
          misc_tp  <= 8'(TP_CODE);
          misc_dly <= 8'(DLY_CODE);
          phase    <= 1'b0;
          drive    <= '0;
          pattern  <= PAT_OFF;
          rx_en    <= 1'b0;
        end
        ST_UNMASK: if (expired) begin
          pattern  <= PAT_ONE;
          rx_en    <= 1'b1;
          drive    <= '0;
          poll_cnt <= '0;
        end
        ST_PH2: if (expired) poll_cnt <= '0;
        ST_POLL: begin
          if (hit) begin
            if (!phase) begin
              int_clr <= 2'b01;
              phase   <= 1'b1;
              pattern <= PAT_TWO;
              drive   <= '0;
            end else begin
              int_clr <= 2'b10;
              result  <= RES_PASS;
              pattern <= PAT_OFF;
            end
          end else if (poll_cnt != LAST_POLL) begin
            poll_cnt <= poll_cnt + 1'b1;
          end else if (drive != LAST_DRV) begin
            drive    <= drive + 1'b1;
            poll_cnt <= '0;
          end else begin
            result  <= phase ? RES_FAIL2 : RES_FAIL1;
            pattern <= PAT_OFF;
            rx_en   <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  // R2
  busy_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
    (result == RES_BUSY) |-> (mask == 2'b00));
  // R3
  misc_before_rx_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_en) |-> (misc_tp == 8'(TP_CODE) && misc_dly == 8'(DLY_CODE)));
  // R4
  drive_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(drive) |-> (drive == $past(drive) + 1'b1 || drive == '0));
  // R6
  pass_rx_on_chk: assert property (@(posedge clk) disable iff (rst)
    (result == RES_PASS) |-> (rx_en && pattern == PAT_OFF));
  // R7
  fail_off_chk: assert property (@(posedge clk) disable iff (rst)
    (result == RES_FAIL1 || result == RES_FAIL2) |-> (!rx_en && pattern == PAT_OFF));
endmodule

// File: rtl/link_lock_trainer.sv
module link_lock_trainer
  import lt_pkg::*;
#(
  parameter int CYC_PER_US = 100,
  parameter int UNMASK_US  = 150,
  parameter int SETTLE_US  = 500,
  parameter int GAP_US     = 50,
  parameter int PH2_US     = 150,
  parameter int POLLS      = 5,
  parameter int DRIVES     = 4,
  parameter int TP_CODE    = 48,
  parameter int DLY_CODE   = 90,
  localparam int DRV_W     = (DRIVES > 1) ? $clog2(DRIVES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             bit_lock_in,
  input  logic             sym_lock_in,
  input  logic [1:0]       sts_clr,
  output logic [1:0]       lock_sts,
  output logic [1:0]       lock_mask,
  output logic [1:0]       pattern_sel,
  output logic [DRV_W-1:0] drive_code,
  output logic             rx_enable,
  output logic [7:0]       misc_tp_code,
  output logic [7:0]       misc_delay_code,
  output logic [2:0]       result
);
  localparam int MAXC = max_of4(UNMASK_US * CYC_PER_US, SETTLE_US * CYC_PER_US,
                                GAP_US * CYC_PER_US, PH2_US * CYC_PER_US);
  localparam int TW   = $clog2(MAXC + 1);

  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_exp;
  logic [1:0]    int_clr;

  lt_timer #(.W(TW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  lt_lock_status #(.NFLAG(2)) u_status (
    .clk(clk), .rst(rst), .mask(lock_mask),
    .set_in({sym_lock_in, bit_lock_in}),
    .host_clr(sts_clr), .int_clr(int_clr), .flags(lock_sts)
  );

  lt_train_fsm #(
    .CYC_PER_US(CYC_PER_US), .UNMASK_US(UNMASK_US), .SETTLE_US(SETTLE_US),
    .GAP_US(GAP_US), .PH2_US(PH2_US), .POLLS(POLLS), .DRIVES(DRIVES),
    .TP_CODE(TP_CODE), .DLY_CODE(DLY_CODE), .TW(TW)
  ) u_fsm (
    .clk(clk), .rst(rst), .start(start), .flags(lock_sts), .expired(tmr_exp),
    .load(tmr_load), .load_val(tmr_val), .mask(lock_mask), .int_clr(int_clr),
    .pattern(pattern_sel), .drive(drive_code), .rx_en(rx_enable),
    .misc_tp(misc_tp_code), .misc_dly(misc_delay_code), .result_o(result)
  );
endmodule

// File: tb/tb_link_lock_trainer.sv
`timescale 1ns/1ps
module tb_link_lock_trainer;
  localparam int CPU = 2;
  localparam int U   = 150 * CPU;
  localparam int S   = 500 * CPU;
  localparam int G   = 50 * CPU;
  localparam int P   = 5;
  localparam int FAIL_TOTAL = U + 4 * (S + P + (P - 1) * G);

  logic clk = 0, rst = 1, start = 0, bit_lock_in = 0, sym_lock_in = 0;
  logic [1:0] sts_clr = 0;
  logic [1:0] lock_sts, lock_mask, pattern_sel, drive_code;
  logic rx_enable;
  logic [7:0] misc_tp_code, misc_delay_code;
  logic [2:0] result;

  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  link_lock_trainer #(.CYC_PER_US(CPU)) dut (
    .clk(clk), .rst(rst), .start(start), .bit_lock_in(bit_lock_in),
    .sym_lock_in(sym_lock_in), .sts_clr(sts_clr), .lock_sts(lock_sts),
    .lock_mask(lock_mask), .pattern_sel(pattern_sel), .drive_code(drive_code),
    .rx_enable(rx_enable), .misc_tp_code(misc_tp_code),
    .misc_delay_code(misc_delay_code), .result(result)
  );

  // rows: d1, o1, d2, o2, expected result, max drive phase 1, max drive phase 2
  localparam int TBL [5][7] = '{
    '{0,    5, 0,   5, 2, 0, 0},
    '{2, 1200, 1,  10, 2, 2, 1},
    '{3, 1300, 3,   0, 2, 3, 3},
    '{4,    0, 0,   0, 3, 3, 0},
    '{1,    0, 4,   0, 4, 1, 3}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run_row(input int d1, input int o1, input int d2, input int o2,
                         output int res, output int m1, output int m2);
    int since;
    int pp, pd;
    m1 = 0; m2 = 0; since = 0; pp = 0; pd = 0;
    @(negedge clk) start = 1;
    @(posedge clk);
    @(negedge clk) start = 0;
    while (result == 3'd1) begin
      if (int'(pattern_sel) != pp || int'(drive_code) != pd) since = 0;
      else since++;
      pp = int'(pattern_sel);
      pd = int'(drive_code);
      if (pp == 1 && pd > m1) m1 = pd;
      if (pp == 2 && pd > m2) m2 = pd;
      bit_lock_in = (pp == 1 && pd == d1 && since == o1);
      sym_lock_in = (pp == 2 && pd == d2 && since == o2);
      @(posedge clk);
      @(negedge clk);
    end
    bit_lock_in = 0;
    sym_lock_in = 0;
    res = int'(result);
  endtask

  initial begin
    int res, m1, m2, n, t1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;

    // R1 reset state
    check("R1 result", result, 0);
    check("R1 pattern", pattern_sel, 0);
    check("R1 mask", lock_mask, 3);
    check("R1 rx_enable", rx_enable, 0);
    check("R1 lock_sts", lock_sts, 0);
    check("R1 misc", {misc_tp_code, misc_delay_code}, 0);

    // R8 masked pulses ignored
    bit_lock_in = 1; sym_lock_in = 1;
    @(posedge clk); @(negedge clk);
    bit_lock_in = 0; sym_lock_in = 0;
    @(posedge clk); @(negedge clk);
    check("R8 masked pulses", lock_sts, 0);

    // R2, R3, R7, R10: no-lock run with exact timing and a start while busy
    start = 1;
    @(posedge clk);
    @(negedge clk) start = 0;
    check("R2 mask cleared", lock_mask, 0);
    check("R2 busy", result, 1);
    n = 0; t1 = -1;
    while (result == 3'd1 && n < 20000) begin
      @(posedge clk); n++;
      @(negedge clk);
      start = 0;
      if (t1 < 0 && pattern_sel == 2'd1) begin
        t1 = n;
        check("R3 rx_enable with pattern 1", rx_enable, 1);
        check("R3 tp code", misc_tp_code, 48);
        check("R3 delay code", misc_delay_code, 90);
      end
      if (n == 2000) start = 1;
    end
    start = 0;
    check("R2 unmask interval", t1, U);
    check("R7 R10 total fail time", n, FAIL_TOTAL);
    check("R7 phase 1 fail", result, 3);
    check("R7 rx off", rx_enable, 0);

    // R4 R5 R6 R7 table walk
    for (int i = 0; i < 5; i++) begin
      run_row(TBL[i][0], TBL[i][1], TBL[i][2], TBL[i][3], res, m1, m2);
      check($sformatf("R6 R7 row %0d result", i), res, TBL[i][4]);
      check($sformatf("R4 row %0d phase1 drive", i), m1, TBL[i][5]);
      check($sformatf("R5 row %0d phase2 drive", i), m2, TBL[i][6]);
      check($sformatf("R6 R7 row %0d pattern off", i), pattern_sel, 0);
      check($sformatf("R6 R7 row %0d rx", i), rx_enable, (TBL[i][4] == 2) ? 1 : 0);
      if (TBL[i][4] == 2) begin
        @(posedge clk); @(negedge clk);
        check($sformatf("R5 R6 row %0d flags cleared", i), lock_sts, 0);
      end
    end

    // R8 R9 sticky flags after a pass
    run_row(0, 0, 0, 0, res, m1, m2);
    @(posedge clk); @(negedge clk);
    sym_lock_in = 1;
    @(posedge clk); @(negedge clk);
    sym_lock_in = 0;
    check("R8 set by pulse", lock_sts, 2);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 sticky", lock_sts, 2);
    sts_clr = 2'b10;
    @(posedge clk); @(negedge clk);
    sts_clr = 0;
    check("R9 write-one clear", lock_sts, 0);
    bit_lock_in = 1; sts_clr = 2'b01;
    @(posedge clk); @(negedge clk);
    bit_lock_in = 0; sts_clr = 0;
    check("R9 set wins", lock_sts, 1);
    start = 1;
    @(posedge clk); @(negedge clk);
    start = 0;
    @(posedge clk); @(negedge clk);
    check("R2 start clears flags", lock_sts, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule